// File: doc/BRIEF.md
# PLL Lock Supervision Timer

This block sits in the bus clock domain beside a clock-multiplying PLL. It holds the PLL's configuration word: reference source, reference divisor, feedback multiplier, output divider, loop filter band and run bit. It watches that word for changes that affect the lock. Each such change starts a timeout that counts bus clock cycles up to a software-programmable limit. When the limit is reached, a timeout flag goes high. The flag says nothing about whether the PLL really locked.

The PLL's own lock indicator enters as a raw asynchronous input. It is synchronised and reported next to the timeout flag. A lock-failure output is high when the timeout has elapsed while the synchronised lock bit is still low. This combination marks a PLL that did not lock in the expected time.

The supervisor is a three-state machine:

- **ST_OFF**: the run bit is clear and the counter is held at zero.
- **ST_WAIT**: the timeout is counting.
- **ST_DONE**: the timeout has elapsed.

Its transitions are:

- **restart**: a lock-relevant change of the configuration word. It moves any state to ST_WAIT if the new run bit is set, and to ST_OFF otherwise. The counter is cleared in both cases.
- **expire**: ST_WAIT moves to ST_DONE once the count is at or above the limit.
- **stop**: any state moves to ST_OFF when the stored run bit is clear.
- **hold**: no other event occurs, and the state stays where it is.

Top module: `pll_lock_supervisor`

## Requirements
- R1: After reset, the outputs are as follows. `timer_expired`, `lock_synced` and `lock_fail` are 0. `cfg_rd` is all zero. `limit_rd` is 12500.
- R2: A configuration write appears on `cfg_rd` after the write edge. The fields sit at these bit positions: run at bit 0, filter band at [3:1], reference source at [8:4], reference divisor at [15:9], multiplier at [22:16] and output divider at [28:23].
- R3: A restarting write is one made with run=1. After such a write at edge E with limit L, `timer_expired` is 0 after edges E+1 through E+L and is 1 after edge E+L+1.
- R4: A write that changes the run bit, the source, the reference divisor, the multiplier or the output divider clears `timer_expired` from the next cycle and restarts the count from zero.
- R5: Two kinds of write have no effect on the timeout. One writes a value identical to the stored word. The other changes only the filter band. In both cases `timer_expired` keeps its value and an ongoing count keeps its original expiry edge.
- R6: While the stored run bit is 0, `timer_expired` stays 0 however long the block waits. Setting the bit again starts a full timeout period.
- R7: The 16-bit limit can be written at any time, is read back on `limit_rd` and does not restart the count. A new limit applies to the run in progress: expiry occurs on the edge after the first edge at which the count is at or above the limit.
- R8: The raw lock input passes through two flip-flops. A change in front of edge A shows on `lock_synced` after edge A+1 and not after edge A.
- R9: `lock_fail` is 1 exactly when `timer_expired` is 1 and `lock_synced` is 0.
- R10: Once set, `timer_expired` stays at 1, independent of the lock input and of limit writes, until a restart or the run bit is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration word write strobe |
| cfg_wr_data | input | 29 | Configuration word to store (layout in R2) |
| limit_wr_en | input | 1 | Timeout limit write strobe |
| limit_wr_data | input | 16 | Timeout limit in bus clock cycles |
| pll_lock_raw | input | 1 | Lock indicator from the PLL, asynchronous |
| cfg_rd | output | 29 | Stored configuration word |
| limit_rd | output | 16 | Stored timeout limit |
| timer_expired | output | 1 | Timeout has elapsed since the last restart |
| lock_synced | output | 1 | Synchronised lock indicator |
| lock_fail | output | 1 | Timeout elapsed without lock |

## Verification
Restarts are driven by changes to each lock-relevant field in turn. These are contrasted with two kinds of write that must be ignored: identical rewrites and changes to the filter band only. The contrast separates a correct field compare from one that restarts on every write or compares the wrong bits.

Limits of zero, small random values and the default are tried, and the flag is checked on every cycle of a run. These runs expose off-by-one errors at the expiry edge. Mid-run limit writes both above and below the current count show whether the limit is applied live or latched at restart.

Random lock levels are held across expiries. They show that the flag ignores lock state while `lock_fail` combines both.

// File: rtl/pll_sup_pkg.sv
package pll_sup_pkg;

    // Configuration word, run bit at the least significant end.
    typedef struct packed {
        logic [5:0] out_div;
        logic [6:0] fb_mult;
        logic [6:0] ref_div;
        logic [4:0] ref_src;
        logic [2:0] loop_band;
        logic       run;
    } pll_cfg_t;

    localparam int CFG_W = $bits(pll_cfg_t);

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_WAIT = 2'd1,
        ST_DONE = 2'd2
    } sup_state_e;

    // True when any field that influences lock differs; the filter band is excluded.
    function automatic logic lock_fields_differ(pll_cfg_t a, pll_cfg_t b);
        return (a.run     != b.run)     ||
               (a.ref_src != b.ref_src) ||
               (a.ref_div != b.ref_div) ||
               (a.fb_mult != b.fb_mult) ||
               (a.out_div != b.out_div);
    endfunction

endpackage

// File: rtl/pll_cfg_store.sv
module pll_cfg_store
    import pll_sup_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output logic [CFG_W-1:0] cfg_q,
    output logic             restart,
    output logic             restart_run
);

    pll_cfg_t stored;
    pll_cfg_t incoming;

    assign incoming    = pll_cfg_t'(wr_data);
    assign cfg_q       = stored;
    assign restart     = wr_en && lock_fields_differ(incoming, stored);
    assign restart_run = incoming.run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stored <= '0;
        end else if (wr_en) begin
            stored <= incoming;
        end
    end

    // R5: rewriting the stored word never produces a restart pulse.
    assert_same_write_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_data == cfg_q)) |-> !restart);

endmodule

// File: rtl/lock_sync.sv
module lock_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];

    generate
        if (STAGES == 2) begin : g_two_stage_check
            // R8: a rising synchronised bit was seen on the raw input two edges earlier.
            assert_sync_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(q) |-> $past(d, 2));
        end
    endgenerate

endmodule

// File: rtl/lock_timeout_fsm.sv
module lock_timeout_fsm
    import pll_sup_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             restart_run,
    input  logic             run_q,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);

    sup_state_e       state, nxt;
    logic [CNT_W-1:0] count;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
        end else begin
            state <= nxt;
        end
    end

    // Transitions: restart, expire, stop, hold.
    always_comb begin
        nxt = state;
        if (restart) begin
            nxt = restart_run ? ST_WAIT : ST_OFF;
        end else begin
            unique case (state)
                ST_OFF:  nxt = run_q ? ST_WAIT : ST_OFF;
                ST_WAIT: begin
                    if (!run_q)              nxt = ST_OFF;
                    else if (count >= limit) nxt = ST_DONE;
                    else                     nxt = ST_WAIT;
                end
                ST_DONE: nxt = run_q ? ST_DONE : ST_OFF;
                default: nxt = ST_OFF;
            endcase
        end
    end

    // Cycle counter.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (restart || state == ST_OFF) begin
            count <= '0;
        end else if (state == ST_WAIT && nxt == ST_WAIT) begin
            count <= count + 1'b1;
        end
    end

    // Outputs.
    always_comb begin
        expired = (state == ST_DONE);
    end

    assert_restart_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!expired && count == '0));

    assert_off_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |-> (!expired && count == '0));

    assert_done_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !restart && run_q) |=> expired);

    assert_reach_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && !restart && run_q && count >= limit) |=> expired);

endmodule

// File: rtl/pll_lock_supervisor.sv
module pll_lock_supervisor
    import pll_sup_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int RESET_LIMIT = 12500,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr_en,
    input  logic [CFG_W-1:0] cfg_wr_data,
    input  logic             limit_wr_en,
    input  logic [CNT_W-1:0] limit_wr_data,
    input  logic             pll_lock_raw,
    output logic [CFG_W-1:0] cfg_rd,
    output logic [CNT_W-1:0] limit_rd,
    output logic             timer_expired,
    output logic             lock_synced,
    output logic             lock_fail
);

    localparam logic [CNT_W-1:0] LIMIT_INIT = CNT_W'(RESET_LIMIT);

    logic             restart;
    logic             restart_run;
    logic [CFG_W-1:0] cfg_q;
    logic [CNT_W-1:0] limit_q;
    pll_cfg_t         cfg_view;

    pll_cfg_store u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (cfg_wr_en),
        .wr_data     (cfg_wr_data),
        .cfg_q       (cfg_q),
        .restart     (restart),
        .restart_run (restart_run)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            limit_q <= LIMIT_INIT;
        end else if (limit_wr_en) begin
            limit_q <= limit_wr_data;
        end
    end

    assign cfg_view = pll_cfg_t'(cfg_q);

    lock_timeout_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .restart     (restart),
        .restart_run (restart_run),
        .run_q       (cfg_view.run),
        .limit       (limit_q),
        .expired     (timer_expired)
    );

    lock_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pll_lock_raw),
        .q     (lock_synced)
    );

    assign cfg_rd    = cfg_q;
    assign limit_rd  = limit_q;
    assign lock_fail = timer_expired && !lock_synced;

endmodule

// File: tb/pll_lock_supervisor_tb_top.sv
module pll_lock_supervisor_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [28:0] cfg_wr_data = '0;
    logic        limit_wr_en = 1'b0;
    logic [15:0] limit_wr_data = '0;
    logic        pll_lock_raw = 1'b0;
    logic [28:0] cfg_rd;
    logic [15:0] limit_rd;
    logic        timer_expired;
    logic        lock_synced;
    logic        lock_fail;

    int unsigned cyc = 0;
    int          checks = 0;
    int          errors = 0;
    logic        finished = 1'b0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pll_lock_supervisor dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_wr_en     (cfg_wr_en),
        .cfg_wr_data   (cfg_wr_data),
        .limit_wr_en   (limit_wr_en),
        .limit_wr_data (limit_wr_data),
        .pll_lock_raw  (pll_lock_raw),
        .cfg_rd        (cfg_rd),
        .limit_rd      (limit_rd),
        .timer_expired (timer_expired),
        .lock_synced   (lock_synced),
        .lock_fail     (lock_fail)
    );

    function automatic logic [28:0] pack_cfg(logic [5:0] od, logic [6:0] mu, logic [6:0] rd,
                                             logic [4:0] src, logic [2:0] band, logic run);
        return {od, mu, rd, src, band, run};
    endfunction

    function automatic logic exp_expired(int unsigned start, int unsigned lim, int unsigned now);
        return (now - start) > lim;
    endfunction

    function automatic logic exp_fail(logic exp_exp, logic lock_lvl);
        return exp_exp && !lock_lvl;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr_cfg(logic [28:0] v);
        cfg_wr_en   = 1'b1;
        cfg_wr_data = v;
        @(posedge clk);
        @(negedge clk);
        cfg_wr_en   = 1'b0;
    endtask

    task automatic wr_lim(logic [15:0] v);
        limit_wr_en   = 1'b1;
        limit_wr_data = v;
        @(posedge clk);
        @(negedge clk);
        limit_wr_en   = 1'b0;
    endtask

    // Check the flag every cycle from now until edge start+upto.
    task automatic run_expect(string tag, int unsigned start, int unsigned lim, int unsigned upto);
        while ((cyc - start) <= upto) begin
            check(tag, timer_expired, exp_expired(start, lim, cyc));
            if ((cyc - start) == upto) break;
            step();
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R3 watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned e;
        logic [28:0] cur;
        void'($urandom(32'd4242));

        repeat (4) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        check("R1 expired",  timer_expired, 0);
        check("R1 synced",   lock_synced, 0);
        check("R1 fail",     lock_fail, 0);
        check("R1 cfg",      cfg_rd, 0);
        check("R1 limit",    limit_rd, 16'd12500);

        // R3 with the default limit
        cur = pack_cfg(6'd3, 7'd20, 7'd1, 5'd4, 3'd6, 1'b1);
        wr_cfg(cur);
        e = cyc;
        check("R2 readback", cfg_rd, cur);
        check("R2 run bit position", cfg_rd[0], 1'b1);
        while ((cyc - e) < 12500) step();
        check("R3 default limit not yet", timer_expired, 0);
        step();
        check("R3 default limit reached", timer_expired, 1);
        check("R9 fail without lock", lock_fail, 1);

        // R8 synchroniser latency
        pll_lock_raw = 1'b1;
        step();
        check("R8 after one edge", lock_synced, 0);
        step();
        check("R8 after two edges", lock_synced, 1);
        check("R9 fail cleared by lock", lock_fail, 0);
        check("R10 flag independent of lock", timer_expired, 1);

        // R5 filter-band-only change
        cur[3:1] = 3'd2;
        wr_cfg(cur);
        check("R2 band readback", cfg_rd[3:1], 3'd2);
        repeat (5) begin
            check("R5 band change ignored", timer_expired, 1);
            step();
        end

        // R7 limit write does not restart; R10 sticky
        wr_lim(16'd10);
        check("R7 limit readback", limit_rd, 16'd10);
        check("R10 sticky after limit write", timer_expired, 1);

        // R4 multiplier change restarts
        cur[22:16] = 7'd33;
        wr_cfg(cur);
        e = cyc;
        run_expect("R4 restart on multiplier", e, 10, 11);

        // R5 identical write mid-run, after a divisor change
        cur[15:9] = 7'd5;
        wr_cfg(cur);
        e = cyc;
        run_expect("R4 restart on divisor", e, 10, 3);
        step();
        wr_cfg(cur);
        run_expect("R5 identical write keeps expiry", e, 10, 11);

        // R7 limit lowered below the running count
        wr_lim(16'd30);
        cur[8:4] = 5'd17;
        wr_cfg(cur);
        e = cyc;
        while ((cyc - e) < 4) step();
        check("R7 before lower", timer_expired, 0);
        wr_lim(16'd2);
        check("R7 lowered limit edge+0", timer_expired, 0);
        step();
        check("R7 lowered limit edge+1", timer_expired, 1);

        // R6 disable, hold, re-enable
        pll_lock_raw = 1'b0;
        cur[0] = 1'b0;
        wr_cfg(cur);
        repeat (40) begin
            check("R6 held low while stopped", timer_expired, 0);
            check("R9 no fail while stopped", lock_fail, 0);
            step();
        end
        wr_lim(16'd7);
        cur[0] = 1'b1;
        wr_cfg(cur);
        e = cyc;
        run_expect("R6 full period after re-enable", e, 7, 8);

        // R4 output divider change with limit zero
        wr_lim(16'd0);
        cur[28:23] = 6'd41;
        wr_cfg(cur);
        e = cyc;
        run_expect("R3 zero limit", e, 0, 2);

        // Random runs
        for (int it = 0; it < 25; it++) begin
            logic [28:0] nxt;
            int unsigned lim;
            logic lvl;
            lim = $urandom_range(0, 31);
            lvl = 1'($urandom_range(0, 1));
            pll_lock_raw = lvl;
            wr_lim(16'(lim));
            step();
            step();
            nxt = {28'($urandom), 1'b1};
            if (nxt[28:4] == cur[28:4]) nxt[4] = ~nxt[4];
            wr_cfg(nxt);
            cur = nxt;
            e = cyc;
            while ((cyc - e) <= lim + 2) begin
                check("R3 random run", timer_expired, exp_expired(e, lim, cyc));
                check("R9 random fail", lock_fail, exp_fail(exp_expired(e, lim, cyc), lvl));
                check("R8 random level", lock_synced, lvl);
                step();
            end
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule